// File: doc/BRIEF.md
# Burst-Limited FIFO Transfer Chunker

This block moves a byte buffer of any length between local storage and the data FIFO register of a peripheral that sits behind a register-transaction framer. The framer carries one register transaction at a time. Before every chunk, the chunker reads the peripheral's 32-bit status register to learn how many bytes the peripheral will accept or supply right now. That figure is the burst count. The chunker then issues one FIFO transaction whose length is the smallest of three values: the bytes still outstanding, that burst count and 64. A burst count of zero means the peripheral is busy, so the status register is polled again and no data moves.

A controller starts a transfer with a length and a direction, then waits for the one-cycle completion pulse. Data flows through a byte-address counter into an external buffer. The counter starts at zero and advances once per data byte. In the read direction the block writes the buffer. In the write direction it reads the buffer combinationally at the current address. If any framer transaction reports a timeout, the transfer is abandoned and completes with the error flag raised.

Top module: `bchunk_top`

## Requirements
- R1: After reset, `cmd_busy`, `cmd_done`, `cmd_err`, `fr_req` and `buf_we` are 0, and `buf_addr` is 0.
- R2: `cmd_start` is taken only while the block is idle. A start pulse during a transfer has no effect on that transfer's transactions or its completion.
- R3: Every chunk starts with a status read: `fr_read`=1, `fr_addr`=0xD40018, `fr_size`=4. The four returned bytes form a little-endian word, with byte n in bits 8n+7:8n, and the burst count is bits 23:8 of that word.
- R4: A burst count of 0 leads straight to another status read, with no FIFO transaction in between.
- R5: A FIFO transaction uses `fr_addr`=0xD40024 and `fr_read`=`cmd_dir`, where 1 means peripheral to buffer. Its `fr_size` is min(remaining bytes, burst count, 64).
- R6: `buf_addr` is 0 when a transfer begins and rises by one per FIFO data byte. In the read direction, `buf_we` pulses with `buf_wdata`=`fr_rd_data` for each FIFO byte. Status bytes never write the buffer.
- R7: In the write direction, `fr_wr_data` carries the buffer byte at `buf_addr`, so the bytes leave in address order 0, 1, 2, and so on.
- R8: When a FIFO transaction ends without a timeout, the remaining count drops by its size. At zero, `cmd_done` pulses for one cycle and `cmd_busy` falls in that same cycle; otherwise a new status read follows.
- R9: A start with length 0 raises `cmd_done` in the cycle after the start and makes no framer request.
- R10: A timeout on any transaction, status or data, ends the transfer at once with `cmd_done` and `cmd_err` both set. This holds even when the data transaction would have finished the length. `cmd_err` stays set until the next accepted start.
- R11: `fr_req` stays high, with `fr_read`, `fr_addr` and `fr_size` unchanged, until the cycle in which `fr_gnt` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start a transfer (taken when idle) |
| cmd_dir | input | 1 | 1: peripheral to buffer, 0: buffer to peripheral |
| cmd_len | input | LEN_W | Number of bytes to move |
| cmd_busy | output | 1 | Transfer in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Last transfer aborted by a timeout |
| fr_req | output | 1 | Transaction request to the framer |
| fr_read | output | 1 | Requested transaction is a read |
| fr_addr | output | 24 | Register address of the transaction |
| fr_size | output | 7 | Byte count of the transaction (1..64) |
| fr_gnt | input | 1 | Framer accepts the request |
| fr_done | input | 1 | Framer finished the transaction |
| fr_timeout | input | 1 | Qualifies `fr_done`: flow-control timeout |
| fr_rd_valid | input | 1 | One read byte present on `fr_rd_data` |
| fr_rd_data | input | 8 | Read byte from the framer |
| fr_wr_pull | input | 1 | Framer consumes `fr_wr_data` this cycle |
| fr_wr_data | output | 8 | Write byte to the framer |
| buf_addr | output | LEN_W | Byte address into the local buffer |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer byte at `buf_addr` |

## Verification
Two things can meet in one cycle. One is the timeout of the data transaction that would also have completed the length; the other is a new start that arrives while the previous completion pulse is still high. The bench makes the framer time out the last data chunk of a read. It then drives the next start at the very edge where `cmd_done` is high. The result is judged by a per-cycle reference model. That model expects the aborted transfer to report done with the error flag set. It also expects the new start to be accepted, to clear the flag and to run its own status read.

// File: rtl/bchunk_pkg.sv
// Shared constants and types for the burst-limited FIFO transfer chunker.
// Assumes a single locality and a 24-bit register address space.
package bchunk_pkg;
    localparam int              ADDR_W     = 24;
    localparam logic [23:0]     LOC_BASE   = 24'hD40000;
    localparam logic [23:0]     STS_OFS    = 24'h000018;
    localparam logic [23:0]     FIFO_OFS   = 24'h000024;
    localparam int              STS_BYTES  = 4;
    localparam int              BURST_LSB  = 8;
    localparam int              BURST_W    = 16;
    localparam int              CHUNK_MAX  = 64;
    localparam int              SIZE_W     = $clog2(CHUNK_MAX + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STS_ASK,
        PH_STS_WAIT,
        PH_DAT_ASK,
        PH_DAT_MOVE
    } phase_t;
endpackage

// File: rtl/bchunk_status_capture.sv
// Gathers the bytes of a status-register read into a little-endian word
// and exposes the burst count field. Assumes bytes arrive in order, lowest
// first, and that a clear precedes each new read.
module bchunk_status_capture #(
    parameter int NBYTES    = 4,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  byte_vld,
    input  logic [7:0]            byte_in,
    output logic [NBYTES*8-1:0]   word_o,
    output logic [FIELD_W-1:0]    field_o
);
    localparam int IDX_W = $clog2(NBYTES) + 1;

    logic [IDX_W-1:0] lane_idx;

    // Track which byte lane receives the next incoming byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_idx <= '0;
        end else if (clear) begin
            lane_idx <= '0;
        end else if (byte_vld && (lane_idx < IDX_W'(NBYTES))) begin
            lane_idx <= lane_idx + 1'b1;
        end
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        // Latch one byte lane when its turn comes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_o[g*8 +: 8] <= 8'h00;
            end else if (clear) begin
                word_o[g*8 +: 8] <= 8'h00;
            end else if (byte_vld && (lane_idx == IDX_W'(g))) begin
                word_o[g*8 +: 8] <= byte_in;
            end
        end
    end

    assign field_o = word_o[FIELD_LSB +: FIELD_W];

    // A clear always leaves an empty word behind.
    p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word_o == '0));

    // The first byte after a clear lands in the lowest lane.
    p_first_lane_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_idx == '0) && byte_vld && !clear |=> (word_o[7:0] == $past(byte_in)));
endmodule

// File: rtl/bchunk_size_calc.sv
// Picks the size of the next FIFO transaction as the smallest of the bytes
// left, the reported burst count and the framer cap. Purely combinational;
// assumes the burst count is nonzero when the result is used.
module bchunk_size_calc #(
    parameter int REM_W   = 16,
    parameter int BURST_W = 16,
    parameter int CAP     = 64,
    parameter int SIZE_W  = 7
) (
    input  logic [REM_W-1:0]   remaining,
    input  logic [BURST_W-1:0] burst,
    output logic [SIZE_W-1:0]  size_o
);
    localparam int CMP_W = (REM_W > BURST_W) ? REM_W + 1 : BURST_W + 1;

    logic [CMP_W-1:0] rem_x;
    logic [CMP_W-1:0] burst_x;
    logic [CMP_W-1:0] cap_x;
    logic [CMP_W-1:0] pick_a;
    logic [CMP_W-1:0] pick_b;

    // Widen all three operands and take the minimum in two steps.
    always_comb begin
        rem_x   = CMP_W'(remaining);
        burst_x = CMP_W'(burst);
        cap_x   = CMP_W'(CAP);
        pick_a  = (rem_x < burst_x) ? rem_x : burst_x;
        pick_b  = (pick_a < cap_x) ? pick_a : cap_x;
        size_o  = SIZE_W'(pick_b);
    end
endmodule

// File: rtl/bchunk_tracker.sv
// Holds the outstanding byte count and the buffer byte address of the
// current transfer. Assumes a consume never exceeds what is outstanding.
module bchunk_tracker #(
    parameter int LEN_W  = 16,
    parameter int SIZE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  len,
    input  logic              step,
    input  logic              consume,
    input  logic [SIZE_W-1:0] size,
    output logic [LEN_W-1:0]  rem_o,
    output logic [LEN_W-1:0]  addr_o
);
    // Outstanding bytes: loaded at start, reduced per finished chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_o <= '0;
        end else if (load) begin
            rem_o <= len;
        end else if (consume) begin
            rem_o <= rem_o - LEN_W'(size);
        end
    end

    // Buffer address: cleared at start, advanced per data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (load) begin
            addr_o <= '0;
        end else if (step) begin
            addr_o <= addr_o + 1'b1;
        end
    end

    // The outstanding count never wraps below zero.
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        consume && !load |-> (LEN_W'(size) <= rem_o));

    // Each moved data byte advances the address by exactly one.
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> (addr_o == $past(addr_o) + 1'b1));
endmodule

// File: rtl/bchunk_top.sv
// Burst-limited FIFO transfer chunker. Splits a transfer into FIFO
// transactions whose size follows the burst count read from the status
// register before each chunk, re-polling while that count is zero.
// Assumes the framer returns read bytes in order and raises fr_done only
// after the last byte of a transaction.
module bchunk_top
    import bchunk_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_dir,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_busy,
    output logic              cmd_done,
    output logic              cmd_err,
    output logic              fr_req,
    output logic              fr_read,
    output logic [23:0]       fr_addr,
    output logic [6:0]        fr_size,
    input  logic              fr_gnt,
    input  logic              fr_done,
    input  logic              fr_timeout,
    input  logic              fr_rd_valid,
    input  logic [7:0]        fr_rd_data,
    input  logic              fr_wr_pull,
    output logic [7:0]        fr_wr_data,
    output logic [LEN_W-1:0]  buf_addr,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    localparam logic [23:0] STS_ADDR  = LOC_BASE + STS_OFS;
    localparam logic [23:0] FIFO_ADDR = LOC_BASE + FIFO_OFS;

    phase_t               phase_q;
    phase_t               phase_d;
    logic                 dir_q;
    logic [SIZE_W-1:0]    size_q;
    logic [SIZE_W-1:0]    size_next;
    logic                 done_q;
    logic                 err_q;
    logic [LEN_W-1:0]     rem;
    logic [STS_BYTES*8-1:0] sts_word;
    logic [BURST_W-1:0]   burst;
    logic                 accept;
    logic                 sts_clear;
    logic                 sts_byte;
    logic                 data_byte;
    logic                 chunk_ok;
    logic                 last_chunk;

    assign accept     = (phase_q == PH_IDLE) && cmd_start;
    assign sts_clear  = (phase_q == PH_STS_ASK) && fr_gnt;
    assign sts_byte   = (phase_q == PH_STS_WAIT) && fr_rd_valid;
    assign data_byte  = (phase_q == PH_DAT_MOVE) && (dir_q ? fr_rd_valid : fr_wr_pull);
    assign chunk_ok   = (phase_q == PH_DAT_MOVE) && fr_done && !fr_timeout;
    assign last_chunk = (rem == LEN_W'(size_q));

    bchunk_status_capture #(
        .NBYTES    (STS_BYTES),
        .FIELD_LSB (BURST_LSB),
        .FIELD_W   (BURST_W)
    ) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sts_clear),
        .byte_vld (sts_byte),
        .byte_in  (fr_rd_data),
        .word_o   (sts_word),
        .field_o  (burst)
    );

    bchunk_size_calc #(
        .REM_W   (LEN_W),
        .BURST_W (BURST_W),
        .CAP     (CHUNK_MAX),
        .SIZE_W  (SIZE_W)
    ) u_size (
        .remaining (rem),
        .burst     (burst),
        .size_o    (size_next)
    );

    bchunk_tracker #(
        .LEN_W  (LEN_W),
        .SIZE_W (SIZE_W)
    ) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .len     (cmd_len),
        .step    (data_byte),
        .consume (chunk_ok),
        .size    (size_q),
        .rem_o   (rem),
        .addr_o  (buf_addr)
    );

    // Next-phase decision for the chunk loop.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (cmd_start && (cmd_len != '0)) phase_d = PH_STS_ASK;
            end
            PH_STS_ASK: begin
                if (fr_gnt) phase_d = PH_STS_WAIT;
            end
            PH_STS_WAIT: begin
                if (fr_done) begin
                    if (fr_timeout)        phase_d = PH_IDLE;
                    else if (burst == '0)  phase_d = PH_STS_ASK;
                    else                   phase_d = PH_DAT_ASK;
                end
            end
            PH_DAT_ASK: begin
                if (fr_gnt) phase_d = PH_DAT_MOVE;
            end
            PH_DAT_MOVE: begin
                if (fr_done) begin
                    if (fr_timeout || last_chunk) phase_d = PH_IDLE;
                    else                          phase_d = PH_STS_ASK;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Direction latched at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= 1'b0;
        else if (accept) dir_q <= cmd_dir;
    end

    // Chunk size fixed once the status read gives a nonzero burst count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
        end else if ((phase_q == PH_STS_WAIT) && fr_done && !fr_timeout && (burst != '0)) begin
            size_q <= size_next;
        end
    end

    // Completion pulse: zero length, last good chunk, or any timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (accept && (cmd_len == '0))
                   || (chunk_ok && last_chunk)
                   || (((phase_q == PH_STS_WAIT) || (phase_q == PH_DAT_MOVE)) && fr_done && fr_timeout);
        end
    end

    // Error flag: set by a timeout, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (accept) begin
            err_q <= 1'b0;
        end else if (((phase_q == PH_STS_WAIT) || (phase_q == PH_DAT_MOVE)) && fr_done && fr_timeout) begin
            err_q <= 1'b1;
        end
    end

    assign cmd_busy   = (phase_q != PH_IDLE);
    assign cmd_done   = done_q;
    assign cmd_err    = err_q;
    assign fr_req     = (phase_q == PH_STS_ASK) || (phase_q == PH_DAT_ASK);
    assign fr_read    = (phase_q == PH_STS_ASK) ? 1'b1 : dir_q;
    assign fr_addr    = (phase_q == PH_STS_ASK) ? STS_ADDR : FIFO_ADDR;
    assign fr_size    = (phase_q == PH_STS_ASK) ? SIZE_W'(STS_BYTES) : size_q;
    assign fr_wr_data = buf_rdata;
    assign buf_we     = (phase_q == PH_DAT_MOVE) && dir_q && fr_rd_valid;
    assign buf_wdata  = fr_rd_data;

    // A pending request keeps its attributes until the framer grants it.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fr_req && !fr_gnt |=> fr_req && $stable(fr_addr) && $stable(fr_size) && $stable(fr_read));

    // Every FIFO request carries a size between 1 and the cap.
    p_size_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fr_req && (fr_addr == FIFO_ADDR) |-> (fr_size != '0) && (fr_size <= SIZE_W'(CHUNK_MAX)));

    // A zero-length start completes next cycle without a request.
    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_busy && cmd_start && (cmd_len == '0) |=> cmd_done && !fr_req);

    // Completion always coincides with the block being idle.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !cmd_busy);

    // The error flag only appears together with a completion.
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> cmd_done);

    // Status bytes never reach the buffer.
    p_no_sts_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sts_byte |-> !buf_we);
endmodule

// File: tb/bchunk_top_tb_top.sv
module bchunk_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;
    localparam int WDOG_LIMIT = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_start = 1'b0;
    logic             cmd_dir = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic             cmd_busy, cmd_done, cmd_err;
    logic             fr_req, fr_read;
    logic [23:0]      fr_addr;
    logic [6:0]       fr_size;
    logic             fr_gnt = 1'b0, fr_done = 1'b0, fr_timeout = 1'b0;
    logic             fr_rd_valid = 1'b0, fr_wr_pull = 1'b0;
    logic [7:0]       fr_rd_data = 8'h00;
    logic [7:0]       fr_wr_data;
    logic [LEN_W-1:0] buf_addr;
    logic             buf_we;
    logic [7:0]       buf_wdata;
    logic [7:0]       buf_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] tx_mem [256];
    logic [7:0] rx_mem [256];

    // Framer-side scenario control and records.
    int burst_q[$];
    int size_seen[$];
    int wr_seen[$];
    int sts_cnt;
    int txn_idx;
    int timeout_at;
    int rd_seq;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign buf_rdata = tx_mem[buf_addr[7:0]];

    always @(posedge clk) if (buf_we) rx_mem[buf_addr[7:0]] <= buf_wdata;

    bchunk_top #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_dir(cmd_dir), .cmd_len(cmd_len),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .fr_req(fr_req), .fr_read(fr_read), .fr_addr(fr_addr), .fr_size(fr_size),
        .fr_gnt(fr_gnt), .fr_done(fr_done), .fr_timeout(fr_timeout),
        .fr_rd_valid(fr_rd_valid), .fr_rd_data(fr_rd_data),
        .fr_wr_pull(fr_wr_pull), .fr_wr_data(fr_wr_data),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    int m_ph = 0;      // 0 idle, 1 status ask, 2 status wait, 3 data ask, 4 data move
    int m_rem = 0, m_chunk = 0, m_addr = 0, m_nb = 0;
    int m_dir = 0, m_done = 0, m_err = 0;
    longint m_word = 0;

    always @(posedge clk) begin
        int b;
        if (!rst_n) begin
            m_ph = 0; m_rem = 0; m_chunk = 0; m_addr = 0; m_done = 0; m_err = 0; m_dir = 0;
        end else begin
            m_done = 0;
            case (m_ph)
                0: if (cmd_start) begin
                    m_err = 0; m_addr = 0; m_rem = int'(cmd_len); m_dir = int'(cmd_dir);
                    if (cmd_len == 0) m_done = 1; else m_ph = 1;
                end
                1: if (fr_gnt) begin m_ph = 2; m_nb = 0; m_word = 0; end
                2: begin
                    if (fr_rd_valid) begin
                        m_word = m_word | (longint'(fr_rd_data) << (8 * m_nb));
                        m_nb++;
                    end else if (fr_done) begin
                        b = int'((m_word >> 8) & 64'hFFFF);
                        if (fr_timeout) begin m_err = 1; m_done = 1; m_ph = 0; end
                        else if (b == 0) m_ph = 1;
                        else begin
                            m_chunk = m_rem;
                            if (b < m_chunk) m_chunk = b;
                            if (64 < m_chunk) m_chunk = 64;
                            m_ph = 3;
                        end
                    end
                end
                3: if (fr_gnt) m_ph = 4;
                4: begin
                    if ((m_dir == 1 && fr_rd_valid) || (m_dir == 0 && fr_wr_pull)) m_addr++;
                    if (fr_done) begin
                        if (fr_timeout) begin m_err = 1; m_done = 1; m_ph = 0; end
                        else begin
                            m_rem = m_rem - m_chunk;
                            if (m_rem == 0) begin m_done = 1; m_ph = 0; end
                            else m_ph = 1;
                        end
                    end
                end
                default: m_ph = 0;
            endcase
        end
    end

    // Per-cycle comparison, a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        chk("R8 busy", cmd_busy, m_ph != 0);
        chk("R8 done", cmd_done, m_done);
        chk("R10 err", cmd_err, m_err);
        chk("R11 req", fr_req, (m_ph == 1) || (m_ph == 3));
        chk("R6 buf_addr", buf_addr, m_addr);
        chk("R6 buf_we", buf_we, (m_ph == 4) && (m_dir == 1) && fr_rd_valid);
        if (buf_we) chk("R6 buf_wdata", buf_wdata, fr_rd_data);
        if (m_ph == 1) begin
            chk("R3 sts read", fr_read, 1);
            chk("R3 sts addr", fr_addr, 24'hD40018);
            chk("R3 sts size", fr_size, 4);
        end
        if (m_ph == 3) begin
            chk("R5 fifo dir", fr_read, m_dir);
            chk("R5 fifo addr", fr_addr, 24'hD40024);
            chk("R5 fifo size", fr_size, m_chunk);
        end
    end

    // Framer responder: grant, byte phase, then done.
    initial begin
        forever begin
            @(negedge clk);
            fr_done = 1'b0; fr_timeout = 1'b0;
            if (rst_n && fr_req) begin
                automatic int n = int'(fr_size);
                automatic bit is_sts = (fr_addr == 24'hD40018);
                automatic bit rd = fr_read;
                automatic int bc = 64;
                automatic logic [31:0] w;
                if (is_sts) begin
                    sts_cnt++;
                    if (burst_q.size() > 0) bc = burst_q.pop_front();
                end else begin
                    size_seen.push_back(n);
                end
                w = {8'h3C, bc[15:0], 8'hA5};
                fr_gnt = 1'b1;
                @(negedge clk);
                fr_gnt = 1'b0;
                for (int i = 0; i < n; i++) begin
                    if (is_sts) begin
                        fr_rd_valid = 1'b1; fr_rd_data = w[i*8 +: 8];
                    end else if (rd) begin
                        fr_rd_valid = 1'b1; fr_rd_data = 8'(8'h40 + rd_seq); rd_seq++;
                    end else begin
                        wr_seen.push_back(int'(fr_wr_data));
                        fr_wr_pull = 1'b1;
                    end
                    @(negedge clk);
                end
                fr_rd_valid = 1'b0; fr_wr_pull = 1'b0;
                fr_done = 1'b1;
                fr_timeout = (txn_idx == timeout_at);
                txn_idx++;
            end
        end
    end

    task automatic prep(input int to_at);
        size_seen.delete(); wr_seen.delete();
        sts_cnt = 0; txn_idx = 0; timeout_at = to_at; rd_seq = 0;
        for (int i = 0; i < 256; i++) rx_mem[i] = 8'h00;
    endtask

    // Called at a falling edge: drive a one-cycle start.
    task automatic pulse_start(input bit dir, input int len);
        cmd_dir = dir; cmd_len = LEN_W'(len); cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_done();
        while (!cmd_done) @(negedge clk);
    endtask

    task automatic check_sizes(input string tag, input int exp[$]);
        chk({tag, " chunk count"}, size_seen.size(), exp.size());
        for (int i = 0; i < exp.size() && i < size_seen.size(); i++)
            chk({tag, " chunk size"}, size_seen[i], exp[i]);
    endtask

    task automatic check_tx(input string tag, input int len);
        chk({tag, " bytes sent"}, wr_seen.size(), len);
        for (int i = 0; i < len && i < wr_seen.size(); i++)
            chk({tag, " byte order"}, wr_seen[i], tx_mem[i]);
    endtask

    task automatic check_rx(input string tag, input int len);
        for (int i = 0; i < len; i++)
            chk({tag, " buffer byte"}, rx_mem[i], 8'(8'h40 + i));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) tx_mem[i] = 8'(i * 7 + 3);
        prep(-1);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", cmd_busy, 0);
        chk("R1 done", cmd_done, 0);
        chk("R1 err", cmd_err, 0);
        chk("R1 req", fr_req, 0);
        chk("R1 buf_addr", buf_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R7: single write chunk limited by remaining bytes
        prep(-1); burst_q = '{32};
        pulse_start(1'b0, 10); wait_done();
        chk("R7 err", cmd_err, 0);
        check_sizes("R5 write", '{10});
        check_tx("R7 write", 10);
        repeat (2) @(negedge clk);

        // R5 R6: read capped at 64 per chunk
        prep(-1); burst_q = '{256, 256, 256};
        pulse_start(1'b1, 150); wait_done();
        check_sizes("R5 cap", '{64, 64, 22});
        chk("R3 status reads", sts_cnt, 3);
        check_rx("R6 read", 150);
        repeat (2) @(negedge clk);

        // R4: zero burst re-polls, burst limits chunk
        prep(-1); burst_q = '{0, 0, 8, 5, 100};
        pulse_start(1'b0, 20); wait_done();
        check_sizes("R4 repoll", '{8, 5, 7});
        chk("R4 status reads", sts_cnt, 5);
        check_tx("R4 write", 20);
        repeat (2) @(negedge clk);

        // R9: zero length
        prep(-1);
        pulse_start(1'b1, 0);
        chk("R9 done next cycle", cmd_done, 1);
        chk("R9 no status read", sts_cnt, 0);
        repeat (3) @(negedge clk);
        chk("R9 no request", sts_cnt + size_seen.size(), 0);

        // R10: timeout on the final data chunk, then start while done is high
        prep(3); burst_q = '{16, 16};
        pulse_start(1'b1, 30); wait_done();
        chk("R10 err on final chunk", cmd_err, 1);
        check_sizes("R10 sizes", '{16, 14});
        prep(-1); burst_q = '{5};
        pulse_start(1'b1, 5);
        chk("R10 err cleared", cmd_err, 0);
        wait_done();
        chk("R10 follow-up err", cmd_err, 0);
        check_sizes("R10 follow-up", '{5});
        repeat (2) @(negedge clk);

        // R10: timeout on a status read
        prep(0); burst_q = '{8};
        pulse_start(1'b0, 8); wait_done();
        chk("R10 status timeout err", cmd_err, 1);
        check_sizes("R10 status timeout", '{});
        repeat (2) @(negedge clk);

        // R2: start during a transfer is ignored
        prep(-1); burst_q = '{0, 0, 40};
        pulse_start(1'b0, 40);
        repeat (2) @(negedge clk);
        pulse_start(1'b1, 3);
        wait_done();
        check_sizes("R2 ignored start", '{40});
        chk("R2 status reads", sts_cnt, 3);
        check_tx("R2 write", 40);
        repeat (3) @(negedge clk);
        chk("R2 stays idle", cmd_busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule